// File: doc/BRIEF.md
# Multithreaded Pipeline Flush Arbiter

This block decides, once per cycle, which instructions of an in-order multithreaded pipeline must be discarded after a misprediction, a fault or a trap. Several pipeline stages, plus the graduation stage, may each raise a flush request. A request names a thread, the sequence number of the instruction that raised it, and whether that instruction faulted, is a control transfer, or falls through to its sequential successor. From these the block works out a per-thread boundary: every instruction of that thread younger than the boundary is discarded.

The winning boundary per thread is registered. It drives a kill vector over the entries of the stage buffers, and it steers the per-thread fetch address. A clean redirect points fetch at the corrected address and marks it usable. A fault leaves fetch blocked until a trap is delivered, and trap delivery then loads the architectural restart address. Sequence numbers are compared as plain unsigned values. The surrounding pipeline keeps all live numbers inside a window where that comparison is valid.

Top module: `squash_ctrl`

## Requirements
- R1: A request from a faulting instruction gives the boundary seq-1, so the faulting instruction itself is discarded. Fault takes precedence over the control flags.
- R2: A request from a non-faulting, non-control instruction gives a boundary equal to its own sequence number.
- R3: With delay slots enabled (DELAY_SLOT=1), a non-faulting control request whose next address is sequential (seqnext=1) gives the boundary seq+1. Otherwise a control request gives the boundary seq.
- R4: Lane 0 is graduation and lanes 1..NUM_REQ are request ports 0..NUM_REQ-1. For each thread, among all requests in one cycle, the smallest boundary wins, and a tie goes to the lowest lane. sq_vld_o[t] and sq_bnd_o[t] show the winner in the following cycle only. sq_bnd_o holds its value afterwards.
- R5: kill_o[b] is 1 in the cycle after a request exactly when buffer entry b was valid, its thread had a winning request, and its sequence number was strictly greater than that thread's winning boundary.
- R6: A winning faulting request clears fetch_vld_o of its thread one cycle later and leaves fetch_pc_o of that thread unchanged.
- R7: Trap delivery (trap_vld_i) loads fetch_pc_o of the thread with trap_pc_i and sets its fetch_vld_o one cycle later. In the same cycle it takes precedence over any flush of that thread.
- R8: A winning non-faulting request sets fetch_vld_o. A control request redirects fetch_pc_o to its target, or to target+INST_BYTES when the slot instruction is present at the target. A non-control request redirects it to pc+INST_BYTES.
- R9: A graduating instruction with a fault does not commit. It enters arbitration as a faulting request (lane 0), and one cycle later trap_sched_o=1 with trap_sched_tid_o naming its thread. Without a fault, grad_commit_o=1 one cycle later and no flush is raised.
- R10: Reset clears all outputs and all per-thread state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_vld_i | input | NUM_REQ | Flush request valid per stage port |
| req_tid_i | input | NUM_REQ x 2 | Thread of each request |
| req_seq_i | input | NUM_REQ x 16 | Sequence number of requesting instruction |
| req_fault_i | input | NUM_REQ | Requesting instruction faulted |
| req_ctrl_i | input | NUM_REQ | Requesting instruction is a control transfer |
| req_seqnext_i | input | NUM_REQ | Next address is the sequential one |
| req_pc_i | input | NUM_REQ x 32 | Address of requesting instruction |
| req_tgt_i | input | NUM_REQ x 32 | Predicted target of a control request |
| req_slot_vld_i | input | NUM_REQ | A slot instruction follows in the pipeline |
| req_slot_pc_i | input | NUM_REQ x 32 | Address of that slot instruction |
| grad_vld_i | input | 1 | Instruction at graduation |
| grad_tid_i | input | 2 | Its thread |
| grad_seq_i | input | 16 | Its sequence number |
| grad_fault_i | input | 1 | It carries a fault |
| trap_vld_i | input | 1 | Trap delivered |
| trap_tid_i | input | 2 | Thread of the trap |
| trap_pc_i | input | 32 | Architectural restart address |
| buf_vld_i | input | BUF_DEPTH | Stage buffer entry valid |
| buf_tid_i | input | BUF_DEPTH x 2 | Entry thread |
| buf_seq_i | input | BUF_DEPTH x 16 | Entry sequence number |
| sq_vld_o | output | NUM_THREADS | Flush accepted for thread last cycle |
| sq_bnd_o | output | NUM_THREADS x 16 | Last accepted boundary per thread |
| kill_o | output | BUF_DEPTH | Discard mask for buffer entries |
| fetch_pc_o | output | NUM_THREADS x 32 | Fetch address per thread |
| fetch_vld_o | output | NUM_THREADS | Fetch address usable |
| grad_commit_o | output | 1 | Graduating instruction committed |
| trap_sched_o | output | 1 | Trap requested by graduation |
| trap_sched_tid_o | output | 2 | Thread of that trap |

## Verification
Two flush sources can hit the same thread in one cycle. Three lanes raise overlapping requests for thread 0, two of them with equal boundaries, one faulting and one clean. The check is that the faulting lower lane wins, which is visible as a blocked fetch, and not the clean higher lane, which would show a redirected address. A second collision is trap delivery in the same cycle as a fault flush of the same thread. There the bench expects the restart address with fetch valid, while the boundary and kill mask still reflect the fault.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
    localparam int unsigned SQ_SEQ_W = 16;
    localparam int unsigned SQ_TID_W = 2;
    localparam int unsigned SQ_PC_W  = 32;

    typedef logic [SQ_SEQ_W-1:0] seq_t;
    typedef logic [SQ_TID_W-1:0] tid_t;
    typedef logic [SQ_PC_W-1:0]  pc_t;

    // one flush request as seen by a lane
    typedef struct packed {
        logic vld;
        tid_t tid;
        seq_t seq;
        logic fault;
        logic ctrl;
        logic seqnext;
        pc_t  pc;
        pc_t  tgt;
        logic slot_vld;
        pc_t  slot_pc;
    } sq_req_t;

    // evaluated request: boundary and fetch redirect
    typedef struct packed {
        logic vld;
        tid_t tid;
        seq_t bnd;
        logic fault;
        pc_t  npc;
    } sq_cand_t;

    // per-thread winner
    typedef struct packed {
        logic vld;
        seq_t bnd;
        logic fault;
        pc_t  npc;
    } sq_win_t;
endpackage

// File: rtl/sq_bound.sv
module sq_bound
    import sqc_pkg::*;
#(
    parameter bit          DELAY_SLOT = 1'b1,
    parameter int unsigned INST_BYTES = 4
) (
    input  sq_req_t  req_i,
    output sq_cand_t cand_o
);
    localparam pc_t STEP = pc_t'(INST_BYTES);

    seq_t ctrl_bnd;
    pc_t  ctrl_npc;

    generate
        if (DELAY_SLOT) begin : g_slot
            // sequential follower is the slot and survives
            assign ctrl_bnd = req_i.seqnext ? (req_i.seq + 1'b1) : req_i.seq;
        end else begin : g_noslot
            logic unused_seqnext;
            assign unused_seqnext = req_i.seqnext;
            assign ctrl_bnd = req_i.seq;
        end
    endgenerate

    always_comb begin
        if (req_i.slot_vld && (req_i.slot_pc == req_i.tgt)) begin
            ctrl_npc = req_i.tgt + STEP;
        end else begin
            ctrl_npc = req_i.tgt;
        end
    end

    always_comb begin
        cand_o.vld   = req_i.vld;
        cand_o.tid   = req_i.tid;
        cand_o.fault = req_i.fault;
        if (req_i.fault) begin
            cand_o.bnd = req_i.seq - 1'b1;
            cand_o.npc = req_i.pc;
        end else if (req_i.ctrl) begin
            cand_o.bnd = ctrl_bnd;
            cand_o.npc = ctrl_npc;
        end else begin
            cand_o.bnd = req_i.seq;
            cand_o.npc = req_i.pc + STEP;
        end
    end
endmodule

// File: rtl/sq_arb.sv
module sq_arb
    import sqc_pkg::*;
#(
    parameter int unsigned NUM_LANES   = 4,
    parameter int unsigned NUM_THREADS = 4
) (
    input  sq_cand_t cand_i [NUM_LANES],
    output sq_win_t  win_o  [NUM_THREADS]
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        always_comb begin
            win_o[t] = '0;
            for (int l = 0; l < NUM_LANES; l++) begin
                // strictly smaller replaces: ties stay with the lower lane
                if (cand_i[l].vld && (cand_i[l].tid == tid_t'(t)) &&
                    (!win_o[t].vld || (cand_i[l].bnd < win_o[t].bnd))) begin
                    win_o[t].vld   = 1'b1;
                    win_o[t].bnd   = cand_i[l].bnd;
                    win_o[t].fault = cand_i[l].fault;
                    win_o[t].npc   = cand_i[l].npc;
                end
            end
        end
    end
endmodule

// File: rtl/sq_kill.sv
module sq_kill
    import sqc_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned BUF_DEPTH   = 8
) (
    input  logic [NUM_THREADS-1:0]             win_vld_i,
    input  logic [NUM_THREADS-1:0][SQ_SEQ_W-1:0] win_bnd_i,
    input  logic [BUF_DEPTH-1:0]               buf_vld_i,
    input  logic [BUF_DEPTH-1:0][SQ_TID_W-1:0] buf_tid_i,
    input  logic [BUF_DEPTH-1:0][SQ_SEQ_W-1:0] buf_seq_i,
    output logic [BUF_DEPTH-1:0]               kill_o
);
    for (genvar b = 0; b < BUF_DEPTH; b++) begin : g_ent
        always_comb begin
            kill_o[b] = 1'b0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (buf_vld_i[b] && win_vld_i[t] &&
                    (buf_tid_i[b] == tid_t'(t)) &&
                    (buf_seq_i[b] > win_bnd_i[t])) begin
                    kill_o[b] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl
    import sqc_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_REQ     = 3,
    parameter int unsigned BUF_DEPTH   = 8,
    parameter bit          DELAY_SLOT  = 1'b1,
    parameter int unsigned INST_BYTES  = 4
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [NUM_REQ-1:0]                 req_vld_i,
    input  logic [NUM_REQ-1:0][SQ_TID_W-1:0]   req_tid_i,
    input  logic [NUM_REQ-1:0][SQ_SEQ_W-1:0]   req_seq_i,
    input  logic [NUM_REQ-1:0]                 req_fault_i,
    input  logic [NUM_REQ-1:0]                 req_ctrl_i,
    input  logic [NUM_REQ-1:0]                 req_seqnext_i,
    input  logic [NUM_REQ-1:0][SQ_PC_W-1:0]    req_pc_i,
    input  logic [NUM_REQ-1:0][SQ_PC_W-1:0]    req_tgt_i,
    input  logic [NUM_REQ-1:0]                 req_slot_vld_i,
    input  logic [NUM_REQ-1:0][SQ_PC_W-1:0]    req_slot_pc_i,
    input  logic                               grad_vld_i,
    input  logic [SQ_TID_W-1:0]                grad_tid_i,
    input  logic [SQ_SEQ_W-1:0]                grad_seq_i,
    input  logic                               grad_fault_i,
    input  logic                               trap_vld_i,
    input  logic [SQ_TID_W-1:0]                trap_tid_i,
    input  logic [SQ_PC_W-1:0]                 trap_pc_i,
    input  logic [BUF_DEPTH-1:0]               buf_vld_i,
    input  logic [BUF_DEPTH-1:0][SQ_TID_W-1:0] buf_tid_i,
    input  logic [BUF_DEPTH-1:0][SQ_SEQ_W-1:0] buf_seq_i,
    output logic [NUM_THREADS-1:0]             sq_vld_o,
    output logic [NUM_THREADS-1:0][SQ_SEQ_W-1:0] sq_bnd_o,
    output logic [BUF_DEPTH-1:0]               kill_o,
    output logic [NUM_THREADS-1:0][SQ_PC_W-1:0] fetch_pc_o,
    output logic [NUM_THREADS-1:0]             fetch_vld_o,
    output logic                               grad_commit_o,
    output logic                               trap_sched_o,
    output logic [SQ_TID_W-1:0]                trap_sched_tid_o
);
    localparam int unsigned NUM_LANES = NUM_REQ + 1;

    typedef struct packed {
        logic [NUM_THREADS-1:0]               sq_vld;
        logic [NUM_THREADS-1:0][SQ_SEQ_W-1:0] bnd;
        logic [BUF_DEPTH-1:0]                 kill;
        logic [NUM_THREADS-1:0][SQ_PC_W-1:0]  fpc;
        logic [NUM_THREADS-1:0]               fvld;
        logic                                 commit;
        logic                                 trap_vld;
        tid_t                                 trap_tid;
    } state_t;

    state_t st_d, st_q;

    sq_req_t  lane_req  [NUM_LANES];
    sq_cand_t lane_cand [NUM_LANES];
    sq_win_t  win       [NUM_THREADS];

    logic [NUM_THREADS-1:0]               win_vld;
    logic [NUM_THREADS-1:0][SQ_SEQ_W-1:0] win_bnd;
    logic [BUF_DEPTH-1:0]                 kill_c;

    // lane 0: graduation fault acts as a faulting flush
    always_comb begin
        lane_req[0]       = '0;
        lane_req[0].vld   = grad_vld_i && grad_fault_i;
        lane_req[0].tid   = grad_tid_i;
        lane_req[0].seq   = grad_seq_i;
        lane_req[0].fault = 1'b1;
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        always_comb begin
            lane_req[r+1].vld      = req_vld_i[r];
            lane_req[r+1].tid      = req_tid_i[r];
            lane_req[r+1].seq      = req_seq_i[r];
            lane_req[r+1].fault    = req_fault_i[r];
            lane_req[r+1].ctrl     = req_ctrl_i[r];
            lane_req[r+1].seqnext  = req_seqnext_i[r];
            lane_req[r+1].pc       = req_pc_i[r];
            lane_req[r+1].tgt      = req_tgt_i[r];
            lane_req[r+1].slot_vld = req_slot_vld_i[r];
            lane_req[r+1].slot_pc  = req_slot_pc_i[r];
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        sq_bound #(
            .DELAY_SLOT (DELAY_SLOT),
            .INST_BYTES (INST_BYTES)
        ) i_bound (
            .req_i  (lane_req[l]),
            .cand_o (lane_cand[l])
        );
    end

    sq_arb #(
        .NUM_LANES   (NUM_LANES),
        .NUM_THREADS (NUM_THREADS)
    ) i_arb (
        .cand_i (lane_cand),
        .win_o  (win)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_win
        assign win_vld[t] = win[t].vld;
        assign win_bnd[t] = win[t].bnd;
    end

    sq_kill #(
        .NUM_THREADS (NUM_THREADS),
        .BUF_DEPTH   (BUF_DEPTH)
    ) i_kill (
        .win_vld_i (win_vld),
        .win_bnd_i (win_bnd),
        .buf_vld_i (buf_vld_i),
        .buf_tid_i (buf_tid_i),
        .buf_seq_i (buf_seq_i),
        .kill_o    (kill_c)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sq_vld   = '0;
        st_d.commit   = 1'b0;
        st_d.trap_vld = 1'b0;
        st_d.kill     = kill_c;

        for (int t = 0; t < NUM_THREADS; t++) begin
            if (win[t].vld) begin
                st_d.sq_vld[t] = 1'b1;
                st_d.bnd[t]    = win[t].bnd;
                if (win[t].fault) begin
                    st_d.fvld[t] = 1'b0;
                end else begin
                    st_d.fpc[t]  = win[t].npc;
                    st_d.fvld[t] = 1'b1;
                end
            end
            // trap restart overrides any same-cycle flush of the thread
            if (trap_vld_i && (trap_tid_i == tid_t'(t))) begin
                st_d.fpc[t]  = trap_pc_i;
                st_d.fvld[t] = 1'b1;
            end
        end

        if (grad_vld_i) begin
            if (grad_fault_i) begin
                st_d.trap_vld = 1'b1;
                st_d.trap_tid = grad_tid_i;
            end else begin
                st_d.commit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sq_vld_o         = st_q.sq_vld;
    assign sq_bnd_o         = st_q.bnd;
    assign kill_o           = st_q.kill;
    assign fetch_pc_o       = st_q.fpc;
    assign fetch_vld_o      = st_q.fvld;
    assign grad_commit_o    = st_q.commit;
    assign trap_sched_o     = st_q.trap_vld;
    assign trap_sched_tid_o = st_q.trap_tid;
endmodule

// File: rtl/sq_checker.sv
module sq_checker
    import sqc_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_REQ     = 3,
    parameter int unsigned BUF_DEPTH   = 8
) (
    input logic                                 clk_i,
    input logic                                 rst_ni,
    input logic [NUM_REQ-1:0]                   req_vld_i,
    input logic                                 grad_vld_i,
    input logic [SQ_TID_W-1:0]                  grad_tid_i,
    input logic [SQ_SEQ_W-1:0]                  grad_seq_i,
    input logic                                 grad_fault_i,
    input logic                                 trap_vld_i,
    input logic [SQ_TID_W-1:0]                  trap_tid_i,
    input logic [SQ_PC_W-1:0]                   trap_pc_i,
    input logic [NUM_THREADS-1:0]               sq_vld_o,
    input logic [NUM_THREADS-1:0][SQ_SEQ_W-1:0] sq_bnd_o,
    input logic [BUF_DEPTH-1:0]                 kill_o,
    input logic [NUM_THREADS-1:0][SQ_PC_W-1:0]  fetch_pc_o,
    input logic [NUM_THREADS-1:0]               fetch_vld_o,
    input logic                                 grad_commit_o,
    input logic                                 trap_sched_o,
    input logic [SQ_TID_W-1:0]                  trap_sched_tid_o
);
    // R5: discards only follow an accepted flush
    assert_kill_needs_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|kill_o) |-> (|sq_vld_o));

    // R4: an accepted flush has a request in the previous cycle
    assert_flush_has_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|sq_vld_o) |-> $past((|req_vld_i) || grad_vld_i));

    // R7: trap delivery loads the restart address
    assert_trap_loads_pc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_vld_i |=> (fetch_vld_o[$past(trap_tid_i)] &&
                        (fetch_pc_o[$past(trap_tid_i)] == $past(trap_pc_i))));

    // R1: a graduation fault bounds its thread at or below seq-1
    assert_grad_fault_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grad_vld_i && grad_fault_i) |=>
            (sq_vld_o[$past(grad_tid_i)] &&
             (sq_bnd_o[$past(grad_tid_i)] <= ($past(grad_seq_i) - 1'b1))));

    // R9: a scheduled trap never coincides with a commit, and flushes its thread
    assert_trap_no_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_sched_o |-> (!grad_commit_o && sq_vld_o[trap_sched_tid_o]));

    // R6: fetch becomes blocked only through a flush of that thread
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assert_block_needs_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(fetch_vld_o[t]) |-> sq_vld_o[t]);
    end
endmodule

bind squash_ctrl sq_checker #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_REQ     (NUM_REQ),
    .BUF_DEPTH   (BUF_DEPTH)
) i_sq_checker (.*);

// File: tb/test_squash_ctrl.sv
module test_squash_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NR = 3;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NR-1:0]        req_vld, req_fault, req_ctrl, req_seqnext, req_slot_vld;
    logic [NR-1:0][1:0]   req_tid;
    logic [NR-1:0][15:0]  req_seq;
    logic [NR-1:0][31:0]  req_pc, req_tgt, req_slot_pc;
    logic                 grad_vld, grad_fault, trap_vld;
    logic [1:0]           grad_tid, trap_tid;
    logic [15:0]          grad_seq;
    logic [31:0]          trap_pc;
    logic [NB-1:0]        buf_vld;
    logic [NB-1:0][1:0]   buf_tid;
    logic [NB-1:0][15:0]  buf_seq;
    logic [NT-1:0]        sq_vld, fetch_vld;
    logic [NT-1:0][15:0]  sq_bnd;
    logic [NB-1:0]        kill;
    logic [NT-1:0][31:0]  fetch_pc;
    logic                 grad_commit, trap_sched;
    logic [1:0]           trap_sched_tid;

    squash_ctrl i_squash_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .req_vld_i(req_vld), .req_tid_i(req_tid), .req_seq_i(req_seq),
        .req_fault_i(req_fault), .req_ctrl_i(req_ctrl), .req_seqnext_i(req_seqnext),
        .req_pc_i(req_pc), .req_tgt_i(req_tgt), .req_slot_vld_i(req_slot_vld),
        .req_slot_pc_i(req_slot_pc),
        .grad_vld_i(grad_vld), .grad_tid_i(grad_tid), .grad_seq_i(grad_seq),
        .grad_fault_i(grad_fault),
        .trap_vld_i(trap_vld), .trap_tid_i(trap_tid), .trap_pc_i(trap_pc),
        .buf_vld_i(buf_vld), .buf_tid_i(buf_tid), .buf_seq_i(buf_seq),
        .sq_vld_o(sq_vld), .sq_bnd_o(sq_bnd), .kill_o(kill),
        .fetch_pc_o(fetch_pc), .fetch_vld_o(fetch_vld),
        .grad_commit_o(grad_commit), .trap_sched_o(trap_sched),
        .trap_sched_tid_o(trap_sched_tid)
    );

    typedef struct packed {
        logic [1:0]  tid;
        logic [15:0] seq;
        logic        fault;
        logic        ctrl;
        logic        snext;
        logic        hit;
        logic [15:0] bnd;
        logic [31:0] epc;
        logic        evld;
    } vec_t;

    // single-lane requests: pc 0x100, target 0x400
    localparam vec_t VECS [6] = '{
        '{2'd0, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0, 16'd100, 32'h104, 1'b1},
        '{2'd1, 16'd200, 1'b1, 1'b0, 1'b0, 1'b0, 16'd199, 32'h000, 1'b0},
        '{2'd2, 16'd300, 1'b0, 1'b1, 1'b1, 1'b0, 16'd301, 32'h400, 1'b1},
        '{2'd3, 16'd400, 1'b0, 1'b1, 1'b0, 1'b0, 16'd400, 32'h400, 1'b1},
        '{2'd2, 16'd310, 1'b0, 1'b1, 1'b1, 1'b1, 16'd311, 32'h404, 1'b1},
        '{2'd0, 16'd50,  1'b1, 1'b1, 1'b1, 1'b0, 16'd49,  32'h104, 1'b0}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        req_vld = '0; req_tid = '0; req_seq = '0; req_fault = '0; req_ctrl = '0;
        req_seqnext = '0; req_pc = '0; req_tgt = '0; req_slot_vld = '0; req_slot_pc = '0;
        grad_vld = 1'b0; grad_tid = '0; grad_seq = '0; grad_fault = 1'b0;
        trap_vld = 1'b0; trap_tid = '0; trap_pc = '0;
        buf_vld = '0; buf_tid = '0; buf_seq = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        clr();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 sq_vld", 64'(sq_vld), 64'h0);
        chk("R10 kill", 64'(kill), 64'h0);
        chk("R10 fetch_vld", 64'(fetch_vld), 64'h0);
        chk("R10 fetch_pc0", 64'(fetch_pc[0]), 64'h0);
        chk("R10 grad/trap", 64'({grad_commit, trap_sched}), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) begin
            clr();
            req_vld[0]      = 1'b1;
            req_tid[0]      = VECS[i].tid;
            req_seq[0]      = VECS[i].seq;
            req_fault[0]    = VECS[i].fault;
            req_ctrl[0]     = VECS[i].ctrl;
            req_seqnext[0]  = VECS[i].snext;
            req_pc[0]       = 32'h100;
            req_tgt[0]      = 32'h400;
            req_slot_vld[0] = 1'b1;
            req_slot_pc[0]  = VECS[i].hit ? 32'h400 : 32'h408;
            buf_vld    = 8'b0000_0111;
            buf_tid[0] = VECS[i].tid;        buf_seq[0] = VECS[i].bnd;
            buf_tid[1] = VECS[i].tid;        buf_seq[1] = VECS[i].bnd + 16'd1;
            buf_tid[2] = VECS[i].tid ^ 2'd1; buf_seq[2] = VECS[i].bnd + 16'd1;
            step();
            chk("R4 sq_vld one-hot", 64'(sq_vld), 64'(4'b1 << VECS[i].tid));
            chk(VECS[i].fault ? "R1 boundary" : (VECS[i].ctrl ? "R3 boundary" : "R2 boundary"),
                64'(sq_bnd[VECS[i].tid]), 64'(VECS[i].bnd));
            chk("R5 kill", 64'(kill), 64'h02);
            chk(VECS[i].fault ? "R6 fetch_pc kept" : "R8 fetch_pc",
                64'(fetch_pc[VECS[i].tid]), 64'(VECS[i].epc));
            chk(VECS[i].fault ? "R6 fetch_vld" : "R8 fetch_vld",
                64'(fetch_vld[VECS[i].tid]), 64'(VECS[i].evld));
        end

        // R4: pulse only, boundary held
        clr();
        step();
        chk("R4 idle sq_vld", 64'(sq_vld), 64'h0);
        chk("R4 bnd held", 64'(sq_bnd[2]), 64'd311);

        // R4: three lanes on thread 0, tie 449 goes to lane of port 1 (fault)
        clr();
        req_vld = 3'b111;
        req_tid = '0;
        req_seq[0] = 16'd500; req_pc[0] = 32'h100;
        req_seq[1] = 16'd450; req_fault[1] = 1'b1; req_pc[1] = 32'h180;
        req_seq[2] = 16'd449; req_pc[2] = 32'h200;
        buf_vld = 8'b0000_0011;
        buf_seq[0] = 16'd449; buf_seq[1] = 16'd450;
        step();
        chk("R4 min boundary", 64'(sq_bnd[0]), 64'd449);
        chk("R4 tie lower lane", 64'(fetch_vld[0]), 64'h0);
        chk("R5 strict greater", 64'(kill), 64'h02);

        // R4: different boundaries on thread 1, younger request loses
        clr();
        req_vld = 3'b101;
        req_tid[0] = 2'd1; req_seq[0] = 16'd700; req_pc[0] = 32'h100;
        req_tid[2] = 2'd1; req_seq[2] = 16'd650; req_ctrl[2] = 1'b1;
        req_tgt[2] = 32'h400; req_pc[2] = 32'h300;
        step();
        chk("R4 older wins bnd", 64'(sq_bnd[1]), 64'd650);
        chk("R8 redirect from winner", 64'(fetch_pc[1]), 64'h400);

        // R7: trap delivery
        clr();
        trap_vld = 1'b1; trap_tid = 2'd1; trap_pc = 32'h800;
        step();
        chk("R7 trap pc", 64'(fetch_pc[1]), 64'h800);
        chk("R7 trap vld", 64'(fetch_vld[1]), 64'h1);

        // R7: trap and fault flush on thread 0 in the same cycle
        clr();
        req_vld[0] = 1'b1; req_tid[0] = 2'd0; req_seq[0] = 16'd60; req_fault[0] = 1'b1;
        trap_vld = 1'b1; trap_tid = 2'd0; trap_pc = 32'h900;
        step();
        chk("R7 trap over flush pc", 64'(fetch_pc[0]), 64'h900);
        chk("R7 trap over flush vld", 64'(fetch_vld[0]), 64'h1);
        chk("R1 flush bnd kept", 64'(sq_bnd[0]), 64'd59);

        // R9: faulting graduation on thread 3
        clr();
        grad_vld = 1'b1; grad_tid = 2'd3; grad_seq = 16'd600; grad_fault = 1'b1;
        step();
        chk("R9 no commit", 64'(grad_commit), 64'h0);
        chk("R9 trap sched", 64'({trap_sched, trap_sched_tid}), 64'h7);
        chk("R9 fault bnd", 64'(sq_bnd[3]), 64'd599);
        chk("R6 grad fault blocks", 64'(fetch_vld[3]), 64'h0);
        chk("R6 grad fault pc kept", 64'(fetch_pc[3]), 64'h400);

        // R9: clean graduation
        clr();
        grad_vld = 1'b1; grad_tid = 2'd2; grad_seq = 16'd320;
        step();
        chk("R9 commit", 64'(grad_commit), 64'h1);
        chk("R9 no trap/flush", 64'({trap_sched, sq_vld}), 64'h0);

        // R10: reset again clears state
        clr();
        rst_n = 1'b0;
        step();
        chk("R10 re-reset fetch", 64'({fetch_vld, fetch_pc[0]}), 64'h0);
        chk("R10 re-reset bnd", 64'(sq_bnd[3]), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule